// File: doc/BRIEF.md
# Masked Status and Interrupt Register Block

This block holds the status, mask and mode registers of a cell-processing engine. Two bus masters can reach it: a host processor, which sees the registers at a 32-bit address carrying a fixed window base, and an embedded controller core, which uses 16-bit local addresses. Internal engine events arrive as one-cycle pulses and set sticky bits in a status register. One extra status bit forwards an external PHY interrupt level.

A mask register selects which status bits may drive the host interrupt line. A mask bit of 1 enables its source and 0 suppresses it. When the host reads the status register it gets the value as it stood, and the block clears only the bits that were both set and enabled. Masked bits stay pending, so the host can pick them up later by unmasking them. Reads by the embedded core have no side effect, so the core can watch the same status without taking events away from the host.

Each port decodes its address into a register selection: none, mode, status, mask or version. Read data is registered, and a read with no selection returns zero.

Top module: `msir_top`

## Requirements
- R1: After reset the mode register, the mask register and every sticky event bit are zero, `host_irq` is low and both read-data outputs are zero.
- R2: A 1 on `evt_pulse[i]` sets sticky status bit i at the next clock edge. The bit then stays set until a clearing host read removes it.
- R3: `host_irq` is high exactly when some status bit (event bits 0..EVT_W-1, PI bit EVT_W) is set and its mask bit at the same position is 1. With a mask of zero, `host_irq` stays low.
- R4: A host read of the status register returns the value before the read. It clears exactly the sticky event bits that were set and had mask bit 1, and leaves set bits with mask bit 0 pending.
- R5: If an event pulse arrives in the same cycle as a clearing host status read, its bit is still set after that edge.
- R6: A read of the status register by the embedded core clears no bit.
- R7: Status bit EVT_W (PI) equals the `phy_irq` level sampled at the previous clock edge. No status read clears it.
- R8: Word offsets decode as follows: 0x000 is the mode register (read/write, MODE_W bits), 0x004 is status (read only), 0x008 is mask (read/write, EVT_W+1 bits) and 0x018 is version (read only, returns VERSION). The host reaches offset o at 0x1001_F000+o and the core at 0xF000+o.
- R9: Reserved offsets (such as 0x014, 0x01C, 0x024 and 0x02C–0x04C), misaligned addresses and addresses outside a port's window read as zero, and writes to them change nothing. Writes to status or version are ignored.
- R10: If both ports write the same register in the same cycle, the host value is stored.
- R11: Read data appears one cycle after a read request. A port's read data is zero in any cycle after which it made no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | Host write (1) or read (0) |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after the request |
| core_sel | input | 1 | Core access request |
| core_wr | input | 1 | Core write (1) or read (0) |
| core_addr | input | CORE_AW | Core byte address |
| core_wdata | input | DATA_W | Core write data |
| core_rdata | output | DATA_W | Core read data, one cycle after the request |
| evt_pulse | input | EVT_W | Engine event pulses |
| phy_irq | input | 1 | External PHY interrupt level |
| host_irq | output | 1 | Interrupt to the host |

## Verification
A wrong sticky or mask bit shows up on `host_irq` in the cycle right after the faulty edge, and on the read data of the next status or mask read. A bad clear shows up only on a later read: a lost event reads back as zero, and a wrongly kept bit holds `host_irq` high. For that reason the bench follows every clearing read with further reads from both ports. Decode faults show at once in the read data of the affected offset, or later as a register changed by a write to another address.

// File: rtl/msir_pkg.sv
package msir_pkg;
    // Register selection produced by each port decoder
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_STAT,
        SEL_MASK,
        SEL_VER
    } reg_sel_e;

    localparam int PAGE_BITS = 8;
    localparam logic [PAGE_BITS-1:0] OFF_MODE = 8'h00;
    localparam logic [PAGE_BITS-1:0] OFF_STAT = 8'h04;
    localparam logic [PAGE_BITS-1:0] OFF_MASK = 8'h08;
    localparam logic [PAGE_BITS-1:0] OFF_VER  = 8'h18;
endpackage

// File: rtl/msir_decode.sv
module msir_decode
    import msir_pkg::*;
#(
    parameter int               ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE  = 16'hF000
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          which
);
    logic in_window;

    // R8, R9: window match and word alignment, then offset decode
    assign in_window = (addr[ADDR_W-1:PAGE_BITS] == BASE[ADDR_W-1:PAGE_BITS])
                       && (addr[1:0] == 2'b00);

    always_comb begin
        which = SEL_NONE;
        if (sel && in_window) begin
            unique case (addr[PAGE_BITS-1:0])
                OFF_MODE: which = SEL_MODE;
                OFF_STAT: which = SEL_STAT;
                OFF_MASK: which = SEL_MASK;
                OFF_VER:  which = SEL_VER;
                default:  which = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/msir_status.sv
module msir_status #(
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt,
    input  logic             phy_irq,
    input  logic             clr_en,
    input  logic [EVT_W-1:0] clr_mask,
    output logic [EVT_W-1:0] sticky_q,
    output logic             pi_q
);
    logic [EVT_W-1:0] clr_bits;

    // R4: only set-and-enabled bits are removed by a clearing read
    assign clr_bits = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            pi_q     <= 1'b0;
        end else begin
            // R2, R5: a new event wins over a same-cycle clear
            sticky_q <= (sticky_q & ~clr_bits) | evt;
            // R7: PI bit tracks the PHY level, never cleared by reads
            pi_q     <= phy_irq;
        end
    end
endmodule

// File: rtl/msir_top.sv
module msir_top
    import msir_pkg::*;
#(
    parameter int                 DATA_W    = 32,
    parameter int                 HOST_AW   = 32,
    parameter int                 CORE_AW   = 16,
    parameter logic [HOST_AW-1:0] HOST_BASE = 32'h1001_F000,
    parameter logic [CORE_AW-1:0] CORE_BASE = 16'hF000,
    parameter int                 EVT_W     = 8,
    parameter int                 MODE_W    = 16,
    parameter logic [DATA_W-1:0]  VERSION   = 32'h0001_0300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               core_sel,
    input  logic               core_wr,
    input  logic [CORE_AW-1:0] core_addr,
    input  logic [DATA_W-1:0]  core_wdata,
    output logic [DATA_W-1:0]  core_rdata,
    input  logic [EVT_W-1:0]   evt_pulse,
    input  logic               phy_irq,
    output logic               host_irq
);
    localparam int STAT_W = EVT_W + 1;

    reg_sel_e            host_which;
    reg_sel_e            core_which;
    logic [MODE_W-1:0]   mode_q;
    logic [STAT_W-1:0]   mask_q;
    logic [EVT_W-1:0]    sticky_q;
    logic                pi_q;
    logic [STAT_W-1:0]   stat_word;
    logic                host_rd;
    logic                core_rd;
    logic                stat_clr;
    logic [DATA_W-1:0]   host_word;
    logic [DATA_W-1:0]   core_word;

    msir_decode #(.ADDR_W(HOST_AW), .BASE(HOST_BASE)) u_host_dec (
        .sel   (host_sel),
        .addr  (host_addr),
        .which (host_which)
    );

    msir_decode #(.ADDR_W(CORE_AW), .BASE(CORE_BASE)) u_core_dec (
        .sel   (core_sel),
        .addr  (core_addr),
        .which (core_which)
    );

    assign host_rd  = host_sel && !host_wr;
    assign core_rd  = core_sel && !core_wr;
    // R4, R6: only the host port has the clearing side effect
    assign stat_clr = host_rd && (host_which == SEL_STAT);

    msir_status #(.EVT_W(EVT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .phy_irq  (phy_irq),
        .clr_en   (stat_clr),
        .clr_mask (mask_q[EVT_W-1:0]),
        .sticky_q (sticky_q),
        .pi_q     (pi_q)
    );

    assign stat_word = {pi_q, sticky_q};

    // R3: interrupt from any enabled pending bit
    assign host_irq = |(stat_word & mask_q);

    function automatic logic [DATA_W-1:0] read_mux(input reg_sel_e w,
                                                   input logic [MODE_W-1:0] md,
                                                   input logic [STAT_W-1:0] st,
                                                   input logic [STAT_W-1:0] mk);
        logic [DATA_W-1:0] r;
        r = '0;
        unique case (w)
            SEL_MODE: r = DATA_W'(md);
            SEL_STAT: r = DATA_W'(st);
            SEL_MASK: r = DATA_W'(mk);
            SEL_VER:  r = VERSION;
            default:  r = '0;
        endcase
        return r;
    endfunction

    assign host_word = read_mux(host_which, mode_q, stat_word, mask_q);
    assign core_word = read_mux(core_which, mode_q, stat_word, mask_q);

    // R11: registered read data, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            core_rdata <= '0;
        end else begin
            host_rdata <= host_rd ? host_word : '0;
            core_rdata <= core_rd ? core_word : '0;
        end
    end

    // R8, R10: writable registers, host wins a collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
        end else begin
            if (host_sel && host_wr && host_which == SEL_MODE)
                mode_q <= host_wdata[MODE_W-1:0];
            else if (core_sel && core_wr && core_which == SEL_MODE)
                mode_q <= core_wdata[MODE_W-1:0];

            if (host_sel && host_wr && host_which == SEL_MASK)
                mask_q <= host_wdata[STAT_W-1:0];
            else if (core_sel && core_wr && core_which == SEL_MASK)
                mask_q <= core_wdata[STAT_W-1:0];
        end
    end
endmodule

// File: rtl/msir_checker.sv
module msir_checker #(
    parameter int DATA_W = 32,
    parameter int EVT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_irq,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              phy_irq,
    input logic [EVT_W-1:0]  evt_pulse,
    input logic [EVT_W-1:0]  sticky_q,
    input logic              pi_q,
    input logic [EVT_W:0]    mask_q,
    input logic              stat_clr
);
    // R2: without a clearing read no sticky bit drops
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R5: every pulsed bit is set after the edge, clear or not
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((sticky_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R4: masked pending bits survive a clearing read
    p_masked_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> ((sticky_q & $past(sticky_q & ~mask_q[EVT_W-1:0]))
                      == $past(sticky_q & ~mask_q[EVT_W-1:0])));

    // R7: PI follows the PHY input with one cycle of delay
    p_pi_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pi_q == $past(phy_irq)));

    // R3: everything masked means no interrupt
    p_mask_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !host_irq);

    // R11: idle host port returns zero next cycle
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> (host_rdata == '0));
endmodule

bind msir_top msir_checker #(.DATA_W(DATA_W), .EVT_W(EVT_W)) u_msir_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_irq   (host_irq),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .phy_irq    (phy_irq),
    .evt_pulse  (evt_pulse),
    .sticky_q   (sticky_q),
    .pi_q       (pi_q),
    .mask_q     (mask_q),
    .stat_clr   (stat_clr)
);

// File: tb/msir_top_test.sv
module msir_top_test;
    localparam logic [31:0] VER = 32'h0001_0300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 0, host_wr = 0;
    logic [31:0] host_addr = 0, host_wdata = 0, host_rdata;
    logic        core_sel = 0, core_wr = 0;
    logic [15:0] core_addr = 0;
    logic [31:0] core_wdata = 0, core_rdata;
    logic [7:0]  evt_pulse = 0;
    logic        phy_irq = 0;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [15:0] m_mode = 0;
    logic [8:0]  m_mask = 0;
    logic [7:0]  m_stk  = 0;
    logic        m_pi   = 0;

    always #5 clk = ~clk;

    msir_top uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_sel(core_sel), .core_wr(core_wr), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .evt_pulse(evt_pulse), .phy_irq(phy_irq), .host_irq(host_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int host_off(input logic [31:0] a);
        if (a[31:8] != 24'h1001F0 || a[1:0] != 2'b00) return -1;
        return int'(a[7:0]);
    endfunction

    function automatic int core_off(input logic [15:0] a);
        if (a[15:8] != 8'hF0 || a[1:0] != 2'b00) return -1;
        return int'(a[7:0]);
    endfunction

    function automatic logic [31:0] model_read(input int off);
        case (off)
            'h00: return {16'h0, m_mode};
            'h04: return {23'h0, m_pi, m_stk};
            'h08: return {23'h0, m_mask};
            'h18: return VER;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input bit rd, input int off);
        if (!rd) return "R11 idle";
        if (off == 'h04) return "R4 status read";
        if (off == 'h00 || off == 'h08 || off == 'h18) return "R8 decode";
        return "R9 unmapped";
    endfunction

    // one clock with the currently driven inputs, model compared afterwards
    task automatic step();
        int ho, co;
        bit hrd, crd;
        logic [31:0] eh, ec;
        string th, tc;
        ho  = host_off(host_addr);
        co  = core_off(core_addr);
        hrd = host_sel && !host_wr;
        crd = core_sel && !core_wr;
        eh  = hrd ? model_read(ho) : 32'h0;
        ec  = crd ? model_read(co) : 32'h0;
        th  = tag_for(hrd, ho);
        tc  = tag_for(crd, co);
        if (hrd && ho == 'h04) m_stk = m_stk & ~m_mask[7:0];
        m_stk = m_stk | evt_pulse;
        m_pi  = phy_irq;
        if (host_sel && host_wr && ho == 'h00) m_mode = host_wdata[15:0];
        else if (core_sel && core_wr && co == 'h00) m_mode = core_wdata[15:0];
        if (host_sel && host_wr && ho == 'h08) m_mask = host_wdata[8:0];
        else if (core_sel && core_wr && co == 'h08) m_mask = core_wdata[8:0];
        @(posedge clk);
        #2;
        check({"host ", th}, host_rdata, eh);
        check({"core ", tc}, core_rdata, ec);
        check("R3 irq", {31'h0, host_irq}, {31'h0, |({m_pi, m_stk} & m_mask)});
        host_sel = 0; host_wr = 0; core_sel = 0; core_wr = 0; evt_pulse = 0;
    endtask

    task automatic h_rd(input logic [7:0] off);
        host_sel = 1; host_wr = 0; host_addr = 32'h1001_F000 | off; step();
    endtask
    task automatic h_wr(input logic [7:0] off, input logic [31:0] d);
        host_sel = 1; host_wr = 1; host_addr = 32'h1001_F000 | off; host_wdata = d; step();
    endtask
    task automatic c_rd(input logic [7:0] off);
        core_sel = 1; core_wr = 0; core_addr = 16'hF000 | off; step();
    endtask
    task automatic c_wr(input logic [7:0] off, input logic [31:0] d);
        core_sel = 1; core_wr = 1; core_addr = 16'hF000 | off; core_wdata = d; step();
    endtask

    function automatic logic [7:0] pick_off();
        case ($urandom % 10)
            0: return 8'h00; 1: return 8'h04; 2: return 8'h04; 3: return 8'h08;
            4: return 8'h18; 5: return 8'h14; 6: return 8'h1C; 7: return 8'h24;
            8: return 8'h4C; default: return 8'h06;
        endcase
    endfunction

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        check("R1 irq in reset", {31'h0, host_irq}, 32'h0);
        check("R1 rdata in reset", host_rdata, 32'h0);
        rst_n = 1;
        h_rd(8'h08);
        check("R1 mask after reset", host_rdata, 32'h0);
        c_rd(8'h00);
        check("R1 mode after reset", core_rdata, 32'h0);

        evt_pulse = 8'h05; step();
        step();
        h_rd(8'h04);
        check("R2 sticky bits", host_rdata, 32'h005);
        h_rd(8'h04);
        check("R4 masked bits kept", host_rdata, 32'h005);
        check("R3 all masked", {31'h0, host_irq}, 32'h0);
        h_wr(8'h08, 32'h004);
        check("R3 unmasked raises irq", {31'h0, host_irq}, 32'h1);
        h_rd(8'h04);
        check("R4 read returns pre-clear", host_rdata, 32'h005);
        check("R4 irq dropped", {31'h0, host_irq}, 32'h0);
        c_rd(8'h04);
        check("R4 only enabled cleared", core_rdata, 32'h001);

        h_wr(8'h08, 32'h001);
        evt_pulse = 8'h01; h_rd(8'h04);
        check("R5 event with clear", host_rdata, 32'h001);
        c_rd(8'h04);
        check("R5 bit still set", core_rdata, 32'h001);
        c_rd(8'h04);
        check("R6 core read no clear", core_rdata, 32'h001);
        check("R6 irq held", {31'h0, host_irq}, 32'h1);
        h_rd(8'h04);
        h_rd(8'h04);
        check("R4 cleared", host_rdata, 32'h000);

        phy_irq = 1; step();
        c_rd(8'h04);
        check("R7 PI visible to core", core_rdata, 32'h100);
        check("R7 PI masked", {31'h0, host_irq}, 32'h0);
        h_wr(8'h08, 32'h100);
        check("R7 PI irq", {31'h0, host_irq}, 32'h1);
        h_rd(8'h04);
        h_rd(8'h04);
        check("R7 PI not cleared", host_rdata, 32'h100);
        phy_irq = 0; step();
        h_rd(8'h04);
        check("R7 PI follows low", host_rdata, 32'h000);

        h_rd(8'h18);
        check("R8 host version", host_rdata, VER);
        c_rd(8'h18);
        check("R8 core version", core_rdata, VER);
        c_wr(8'h00, 32'h1234);
        h_rd(8'h00);
        check("R8 mode write", host_rdata, 32'h1234);
        h_wr(8'h04, 32'hFF); h_wr(8'h18, 32'h0);
        h_rd(8'h18);
        check("R9 version write ignored", host_rdata, VER);
        h_wr(8'h14, 32'hFFFF);
        h_rd(8'h14);
        check("R9 reserved reads zero", host_rdata, 32'h0);
        host_sel = 1; host_wr = 1; host_addr = 32'h1001_E000; host_wdata = 32'h7777; step();
        host_sel = 1; host_wr = 1; host_addr = 32'h1001_F002; host_wdata = 32'h6666; step();
        c_rd(8'h00);
        check("R9 out-of-window write ignored", core_rdata, 32'h1234);
        host_sel = 1; host_wr = 1; host_addr = 32'h1001_F000; host_wdata = 32'hAAAA;
        core_sel = 1; core_wr = 1; core_addr = 16'hF000; core_wdata = 32'h5555; step();
        h_rd(8'h00);
        check("R10 host wins", host_rdata, 32'hAAAA);
        step();
        check("R11 idle zero", host_rdata, 32'h0);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 != 0) begin
                host_sel = 1; host_wr = ($urandom % 4 == 0);
                host_addr = ($urandom % 12 == 0) ? 32'h2001_F000 | pick_off()
                                                 : 32'h1001_F000 | pick_off();
                host_wdata = $urandom;
            end
            if ($urandom % 3 != 0) begin
                core_sel = 1; core_wr = ($urandom % 4 == 0);
                core_addr = ($urandom % 12 == 0) ? 16'hE000 | pick_off()
                                                 : 16'hF000 | pick_off();
                core_wdata = $urandom;
            end
            if ($urandom % 4 == 0) evt_pulse = 8'($urandom);
            if ($urandom % 16 == 0) phy_irq = ~phy_irq;
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule